// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory request into a stream of element addresses. A request gives an addressing mode, a scalar base and a scalar stride. The block then issues one element address per handshake until it has issued as many addresses as the vector length, and pulses `done` when it is finished. It supports three modes. Unit stride walks consecutive elements. Constant stride steps by the stride operand. Indexed mode adds each incoming index element to the base, and serves both gather loads and scatter stores.

The element count comes from a programmable vector-length register. A write to that register is clipped at the maximum vector length `MVL`, and the value in force is captured when a request starts. Addresses are counted in 64-bit element units, so the byte address is the element address shifted left by three, done outside the block. All address arithmetic wraps modulo 2^`ADDR_W`, and no fault is raised. Index elements come in on their own valid/ready stream. Issued addresses leave through a registered valid/ready slot that sustains one address per cycle.

Top module: `vec_addr_gen`

## Requirements
- R1: In unit-stride mode (`mode` = 0), element i is issued at address (base + i) mod 2^ADDR_W.
- R2: In strided mode (`mode` = 1), element i is issued at address (base + i*stride) mod 2^ADDR_W, with stride taken as an unsigned value.
- R3: In indexed mode (`mode` = 2), element i is issued at address (base + index_i) mod 2^ADDR_W. index_i is the i-th value accepted on the index stream, where a value is accepted when `idx_valid` and `idx_ready` are both high at a clock edge. In every other mode `idx_ready` stays low.
- R4: A request issues exactly the vector length captured at its start, as addresses tagged `addr_elem` = 0, 1, 2, … in ascending order. `addr_valid` and `idx_ready` are low whenever `busy` is low.
- R5: The vector-length register resets to MVL. A write of a value greater than MVL stores MVL.
- R6: A request that starts with a vector length of 0 issues no address and still pulses `done`.
- R7: While `addr_valid` is high and `addr_ready` is low, `addr_valid`, `addr_out` and `addr_elem` hold their values into the next cycle.
- R8: `done` is high for exactly one cycle. That cycle follows the acceptance of the last address, or follows the start itself for a zero length. `busy` is high from the cycle after the start up to and including the `done` cycle, and drops afterwards.
- R9: A `start` that arrives while `busy` is high is ignored. Its mode, base and stride have no effect on the request in progress.
- R10: Mode value 3 addresses elements exactly as unit-stride mode does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vl_wr_en | input | 1 | Write strobe for the vector-length register |
| vl_wr_val | input | VL_W | Requested vector length, clipped at MVL |
| start | input | 1 | Begin a request; taken only while idle |
| mode | input | 2 | 0 unit, 1 strided, 2 indexed, 3 same as unit |
| base | input | ADDR_W | Base element address |
| stride | input | ADDR_W | Stride in elements for strided mode |
| idx_valid | input | 1 | Index element present |
| idx_ready | output | 1 | Index element taken this cycle |
| idx_data | input | IDX_W | Unsigned index element |
| addr_valid | output | 1 | Element address present |
| addr_ready | input | 1 | Consumer takes the address this cycle |
| addr_out | output | ADDR_W | Element address |
| addr_elem | output | ELEM_W | Element number of `addr_out` |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The bench sweeps every mode against every vector length from 0 to MVL. It runs each combination twice, once with a consumer that is always ready and once with a consumer and index source that stall in a shifting pattern. This exposes a slot that drops or repeats an element under backpressure, and an index stream that advances when no address was loaded, which would shift every indexed address by one index. Zero length is aimed at a sequencer that emits a stray element 0 or never finishes. Over-length register writes would run past MVL if the clip were missing. Strides and bases chosen to cross the top of the address space catch arithmetic that saturates or carries into a wider result. A second `start` injected in mid-run reveals a design that restarts or captures new operands while busy.

// File: rtl/vag_pkg.sv
package vag_pkg;

   typedef enum logic [1:0] {
      VAG_UNIT    = 2'd0,
      VAG_STRIDED = 2'd1,
      VAG_INDEXED = 2'd2,
      VAG_ALTUNIT = 2'd3
   } vag_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_FIN  = 2'd2
   } vag_state_e;

   function automatic logic mode_uses_index(input logic [1:0] m);
      return m == VAG_INDEXED;
   endfunction

   function automatic logic mode_uses_stride(input logic [1:0] m);
      return m == VAG_STRIDED;
   endfunction

endpackage

// File: rtl/vag_vl_reg.sv
module vag_vl_reg #(
   parameter int MVL  = 32,
   parameter int VL_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [VL_W-1:0] wr_val,
   output logic [VL_W-1:0] vl_q
);
   localparam logic [VL_W-1:0] CAP = VL_W'(MVL);

   if (MVL < 1) begin : g_bad_mvl
      $error("vag_vl_reg: MVL must be at least 1");
   end
   if ((1 << VL_W) <= MVL) begin : g_bad_vlw
      $error("vag_vl_reg: VL_W too narrow for MVL");
   end

   logic [VL_W-1:0] clipped;
   assign clipped = (wr_val > CAP) ? CAP : wr_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vl_q <= CAP;
      end else if (wr_en) begin
         vl_q <= clipped;
      end
   end
endmodule

// File: rtl/vag_seq.sv
module vag_seq
   import vag_pkg::*;
#(
   parameter int VL_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [1:0]      mode,
   input  logic [VL_W-1:0] vl_in,
   input  logic            idx_valid,
   input  logic            addr_ready,
   output logic            start_acc,
   output logic            load,
   output logic            idx_ready,
   output logic            slot_vld,
   output logic [VL_W-1:0] issue_cnt,
   output logic            busy,
   output logic            done
);
   localparam logic [VL_W-1:0] CNT_ONE = VL_W'(1);

   vag_state_e      state_q, state_d;
   logic [VL_W-1:0] vl_lat;
   logic            indexed_lat;
   logic            more, room, src_ok, drain, running;

   assign running   = (state_q == SQ_RUN);
   assign start_acc = (state_q == SQ_IDLE) && start;
   assign more      = (issue_cnt != vl_lat);
   assign room      = !slot_vld || addr_ready;
   assign src_ok    = !indexed_lat || idx_valid;
   assign load      = running && more && room && src_ok;
   assign idx_ready = running && indexed_lat && more && room;
   assign drain     = slot_vld && addr_ready;
   assign busy      = (state_q != SQ_IDLE);
   assign done      = (state_q == SQ_FIN);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE: if (start) state_d = (vl_in == '0) ? SQ_FIN : SQ_RUN;
         SQ_RUN:  if (!more && drain) state_d = SQ_FIN;
         SQ_FIN:  state_d = SQ_IDLE;
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         vl_lat      <= '0;
         indexed_lat <= 1'b0;
         issue_cnt   <= '0;
         slot_vld    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start_acc) begin
            vl_lat      <= vl_in;
            indexed_lat <= mode_uses_index(mode);
            issue_cnt   <= '0;
         end else if (load) begin
            issue_cnt <= issue_cnt + CNT_ONE;
         end
         if (load) begin
            slot_vld <= 1'b1;
         end else if (drain) begin
            slot_vld <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vag_addr_unit.sv
module vag_addr_unit
   import vag_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int IDX_W   = 32,
   parameter int VL_W    = 6,
   parameter int ELEM_W  = 5,
   parameter bit USE_MUL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_acc,
   input  logic [1:0]        mode_in,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [ADDR_W-1:0] stride_in,
   input  logic              load,
   input  logic [VL_W-1:0]   issue_cnt,
   input  logic [IDX_W-1:0]  idx_data,
   output logic [ADDR_W-1:0] addr_q,
   output logic [ELEM_W-1:0] elem_q
);
   localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);

   if (IDX_W > ADDR_W) begin : g_bad_idx
      $error("vag_addr_unit: IDX_W may not exceed ADDR_W");
   end
   if (VL_W > ADDR_W) begin : g_bad_cnt
      $error("vag_addr_unit: VL_W may not exceed ADDR_W");
   end
   if (ELEM_W > VL_W) begin : g_bad_elem
      $error("vag_addr_unit: ELEM_W may not exceed VL_W");
   end

   vag_mode_e         mode_q;
   logic [ADDR_W-1:0] base_q, step_q;
   logic [ADDR_W-1:0] idx_ext, idx_addr, seq_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= VAG_UNIT;
         base_q <= '0;
         step_q <= STEP_ONE;
      end else if (start_acc) begin
         mode_q <= vag_mode_e'(mode_in);
         base_q <= base_in;
         step_q <= mode_uses_stride(mode_in) ? stride_in : STEP_ONE;
      end
   end

   if (IDX_W == ADDR_W) begin : g_idx_full
      assign idx_ext = idx_data;
   end else begin : g_idx_pad
      assign idx_ext = {{(ADDR_W-IDX_W){1'b0}}, idx_data};
   end

   assign idx_addr = base_q + idx_ext;

   if (USE_MUL) begin : g_mul
      logic [ADDR_W-1:0] cnt_ext;
      assign cnt_ext  = ADDR_W'(issue_cnt);
      assign seq_addr = base_q + cnt_ext * step_q;
   end else begin : g_acc
      logic [ADDR_W-1:0] acc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q <= '0;
         end else if (start_acc) begin
            acc_q <= base_in;
         end else if (load) begin
            acc_q <= acc_q + step_q;
         end
      end
      assign seq_addr = acc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         elem_q <= '0;
      end else if (load) begin
         addr_q <= (mode_q == VAG_INDEXED) ? idx_addr : seq_addr;
         elem_q <= issue_cnt[ELEM_W-1:0];
      end
   end
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
   parameter int ADDR_W  = 32,
   parameter int IDX_W   = 32,
   parameter int MVL     = 32,
   parameter bit USE_MUL = 1'b0,
   localparam int VL_W   = $clog2(MVL + 1),
   localparam int ELEM_W = (MVL > 1) ? $clog2(MVL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vl_wr_en,
   input  logic [VL_W-1:0]   vl_wr_val,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   input  logic              idx_valid,
   output logic              idx_ready,
   input  logic [IDX_W-1:0]  idx_data,
   output logic              addr_valid,
   input  logic              addr_ready,
   output logic [ADDR_W-1:0] addr_out,
   output logic [ELEM_W-1:0] addr_elem,
   output logic              busy,
   output logic              done
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("vec_addr_gen: ADDR_W must be at least 2");
   end

   logic [VL_W-1:0] vl_cur;
   logic [VL_W-1:0] issue_cnt;
   logic            start_acc, load;

   vag_vl_reg #(.MVL(MVL), .VL_W(VL_W)) u_vl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (vl_wr_en),
      .wr_val (vl_wr_val),
      .vl_q   (vl_cur)
   );

   vag_seq #(.VL_W(VL_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mode       (mode),
      .vl_in      (vl_cur),
      .idx_valid  (idx_valid),
      .addr_ready (addr_ready),
      .start_acc  (start_acc),
      .load       (load),
      .idx_ready  (idx_ready),
      .slot_vld   (addr_valid),
      .issue_cnt  (issue_cnt),
      .busy       (busy),
      .done       (done)
   );

   vag_addr_unit #(
      .ADDR_W  (ADDR_W),
      .IDX_W   (IDX_W),
      .VL_W    (VL_W),
      .ELEM_W  (ELEM_W),
      .USE_MUL (USE_MUL)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_acc (start_acc),
      .mode_in   (mode),
      .base_in   (base),
      .stride_in (stride),
      .load      (load),
      .issue_cnt (issue_cnt),
      .idx_data  (idx_data),
      .addr_q    (addr_out),
      .elem_q    (addr_elem)
   );
endmodule

// File: rtl/vag_checker.sv
module vag_checker #(
   parameter int ADDR_W = 32,
   parameter int VL_W   = 6,
   parameter int ELEM_W = 5,
   parameter int MVL    = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              addr_valid,
   input logic              addr_ready,
   input logic [ADDR_W-1:0] addr_out,
   input logic [ELEM_W-1:0] addr_elem,
   input logic              idx_ready,
   input logic [VL_W-1:0]   vl_cur
);
   localparam logic [ELEM_W-1:0] ELEM_ONE = ELEM_W'(1);
   localparam logic [VL_W-1:0]   VL_CAP   = VL_W'(MVL);

   p_vl_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vl_cur <= VL_CAP);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && !addr_ready) |=>
         (addr_valid && $stable(addr_out) && $stable(addr_elem)));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   p_busy_until_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!addr_valid && !idx_ready));

   p_elem_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && addr_ready) |=>
         (!addr_valid || (addr_elem == $past(addr_elem) + ELEM_ONE)));

   p_no_slot_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !addr_valid);
endmodule

bind vec_addr_gen vag_checker #(
   .ADDR_W (ADDR_W),
   .VL_W   (VL_W),
   .ELEM_W (ELEM_W),
   .MVL    (MVL)
) u_vag_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .addr_valid (addr_valid),
   .addr_ready (addr_ready),
   .addr_out   (addr_out),
   .addr_elem  (addr_elem),
   .idx_ready  (idx_ready),
   .vl_cur     (vl_cur)
);

// File: tb/test_vec_addr_gen.sv
module test_vec_addr_gen;
   localparam int AW  = 8;
   localparam int IW  = 8;
   localparam int MVL = 8;
   localparam int VW  = 4;
   localparam int EW  = 3;
   localparam int AMASK = (1 << AW) - 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          vl_wr_en;
   logic [VW-1:0] vl_wr_val;
   logic          start;
   logic [1:0]    mode;
   logic [AW-1:0] base, stride;
   logic          idx_valid, idx_ready;
   logic [IW-1:0] idx_data;
   logic          addr_valid, addr_ready;
   logic [AW-1:0] addr_out;
   logic [EW-1:0] addr_elem;
   logic          busy, done;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   vec_addr_gen #(.ADDR_W(AW), .IDX_W(IW), .MVL(MVL), .USE_MUL(1'b0)) i_vec_addr_gen (
      .clk(clk), .rst_n(rst_n), .vl_wr_en(vl_wr_en), .vl_wr_val(vl_wr_val),
      .start(start), .mode(mode), .base(base), .stride(stride),
      .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
      .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out),
      .addr_elem(addr_elem), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   function automatic int idx_val(input int n);
      return (n * 37 + 5) & 255;
   endfunction

   function automatic int exp_addr(input int md, input int b, input int s, input int n);
      case (md)
         1:       return (b + n * s) & AMASK;
         2:       return (b + idx_val(n)) & AMASK;
         default: return (b + n) & AMASK;
      endcase
   endfunction

   task automatic set_vl(input int v);
      @(negedge clk);
      vl_wr_en  = 1'b1;
      vl_wr_val = VW'(v);
      @(negedge clk);
      vl_wr_en  = 1'b0;
   endtask

   task automatic run_op(input int md, input int b, input int s, input int exp_vl,
                         input int stall, input bit poke, input string cnt_req);
      int got = 0;
      int idx_n = 0;
      int guard = 0;
      bit seen_done = 0;
      bit hold_pend = 0;
      bit idxr_bad = 0;
      int hold_a = 0;
      int hold_e = 0;
      string tag;
      tag = (md == 1) ? "R2" : (md == 2) ? "R3" : (md == 3) ? "R10" : "R1";
      @(negedge clk);
      start = 1'b1; mode = 2'(md); base = AW'(b); stride = AW'(s);
      addr_ready = 1'b0; idx_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
      while (!seen_done && guard < 200) begin
         addr_ready = stall ? (((guard * 7 + md) % 3) != 0) : 1'b1;
         idx_valid  = stall ? (((guard * 5) % 4) != 1) : 1'b1;
         idx_data   = IW'(idx_val(idx_n));
         if (poke && got == 2) begin
            // R9: a second request while busy must be ignored
            start = 1'b1; mode = 2'((md + 1) % 4); base = AW'(b ^ 8'h5a); stride = AW'(s + 9);
         end else begin
            start = 1'b0;
         end
         #1;
         if (hold_pend)
            chk(addr_valid && addr_out == AW'(hold_a) && addr_elem == EW'(hold_e),
                "R7 stalled address changed", int'(addr_out), hold_a);
         hold_pend = addr_valid && !addr_ready;
         hold_a = int'(addr_out);
         hold_e = int'(addr_elem);
         if (idx_ready && md != 2) idxr_bad = 1'b1;
         if (done) seen_done = 1'b1;
         if (addr_valid && addr_ready) begin
            chk(int'(addr_elem) == (got & (MVL - 1)), {tag, " element tag (R4)"},
                int'(addr_elem), got);
            chk(int'(addr_out) == exp_addr(md, b, s, got), poke ? {tag, " address (R9 poke)"} : tag,
                int'(addr_out), exp_addr(md, b, s, got));
            got++;
         end
         if (idx_valid && idx_ready) idx_n++;
         @(negedge clk);
         guard++;
      end
      start = 1'b0;
      #1;
      chk(seen_done, "R8 done never seen", 0, 1);
      chk(got == exp_vl, cnt_req, got, exp_vl);
      chk(!done && !busy, "R8 done not single cycle or busy stuck", int'(done) + 2 * int'(busy), 0);
      if (md != 2) chk(!idxr_bad, "R3 idx_ready outside indexed mode", 1, 0);
      else chk(idx_n == exp_vl, "R3 index count", idx_n, exp_vl);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; vl_wr_en = 1'b0; vl_wr_val = '0; start = 1'b0; mode = '0;
      base = '0; stride = '0; idx_valid = 1'b0; idx_data = '0; addr_ready = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(!addr_valid && !busy && !done && !idx_ready, "R4 reset state",
          int'(addr_valid) + int'(busy) + int'(done) + int'(idx_ready), 0);
      rst_n = 1'b1;

      // R5: reset value of the length register is MVL
      run_op(0, 17, 0, MVL, 0, 1'b0, "R5 reset length");
      // R5: over-length writes are clipped
      set_vl(12);
      run_op(0, 3, 0, MVL, 1, 1'b0, "R5 clip 12");
      set_vl(15);
      run_op(1, 7, 5, MVL, 0, 1'b0, "R5 clip 15");

      for (int md = 0; md < 4; md++) begin
         for (int v = 0; v <= MVL; v++) begin
            for (int st = 0; st < 2; st++) begin
               set_vl(v);
               run_op(md, (v * 29 + md * 3 + st * 100) & AMASK,
                      (v * 11 + 3 + st * 64) & AMASK, v, st,
                      (v >= 4) && (st == 1), (v == 0) ? "R6 zero length" : "R4 count");
            end
         end
      end

      // R2 / R3 / R1: wrap across the top of the address space
      set_vl(MVL);
      run_op(1, 240, 37, MVL, 1, 1'b0, "R2 wrap count");
      run_op(2, 250, 0, MVL, 1, 1'b0, "R3 wrap count");
      run_op(0, 252, 0, MVL, 0, 1'b0, "R1 wrap count");
      run_op(1, 9, 255, MVL, 0, 1'b0, "R2 negative-like stride count");

      summary();
      $finish;
   end
endmodule